// File: doc/BRIEF.md
# Reloading Capture Timer/Counter

This block is a 16-bit counter for a small controller. It advances either once per machine cycle (two clocks by default) or once per falling edge seen on an external count pin. The count pin is sampled once per machine cycle. A second external pin, the trigger, does one of two things depending on the mode. In reload mode a trigger falling edge forces the counter back to a programmed reload value. In capture mode a trigger falling edge copies the running count into a capture register while counting goes on.

When the counter passes its top value it raises a sticky overflow flag. In reload mode it restarts from the reload value, and in capture mode it restarts from zero. An output pin can toggle on every overflow, or it can carry a PWM waveform. In the PWM case the reload value sets the period and a compare register sets the duty. Software reaches the block through a simple write port. Both flags stay set until software clears them.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count, the capture register, both flags and the output pin are 0, and the control, reload and compare registers hold 0.
- R2: With run set (control bit 0) and the internal source chosen (control bit 1 = 0), the count grows by exactly one per machine cycle of CLKS_PER_TICK (2) clocks.
- R3: With control bit 1 = 1, the count grows by one for each 1-to-0 change of the count pin. The pin goes through a two-flop synchronizer and is sampled once per machine cycle. Rising edges and steady levels leave the count alone.
- R4: In reload mode (control bit 2 = 0), an increment from 0xFFFF loads the reload register (address 2) and sets the overflow flag.
- R5: In reload mode, a 1-to-0 change on the trigger pin (synchronized and sampled like the count pin) loads the reload value and sets the trigger flag.
- R6: In capture mode (control bit 2 = 1), a trigger falling edge copies the current count into the capture output and sets the trigger flag, and counting continues. An increment from 0xFFFF gives 0 and sets the overflow flag. In reload mode the capture output never changes.
- R7: Flags are sticky. A write to address 4 clears the overflow flag when data bit 0 is 0 and clears the trigger flag when data bit 1 is 0. A bit written as 1 leaves its flag unchanged. A flag set in the same cycle wins over a clear.
- R8: With output mode toggle (control bits 4:3 = 1), the output pin inverts on each overflow.
- R9: With output mode PWM (control bits 4:3 = 2), the output pin is 1 while the count is below the compare register (address 3) and 0 otherwise. Output modes 0 and 3 drive 0.
- R10: With run cleared, the count holds and trigger edges change neither the count, the capture register nor the trigger flag.
- R11: A write to address 1 loads the count on that clock and overrides a same-cycle reload or increment. A write to address 0 sets the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 control, 1 count, 2 reload, 3 compare, 4 flag clear |
| wr_data_i | input | CNT_W | Write data |
| cnt_pin_i | input | 1 | External count input (falling edge counts) |
| trg_pin_i | input | 1 | External trigger input (falling edge reloads or captures) |
| count_o | output | CNT_W | Current count |
| capture_o | output | CNT_W | Captured count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| trg_flag_o | output | 1 | Sticky trigger-event flag |
| out_pin_o | output | 1 | Toggle or PWM output |

## Verification
The bound checker covers the rules that hold on every cycle. A stopped counter never moves. A capture-mode count only holds or steps by one, and its wrap from the top value always raises the overflow flag. The capture register is frozen in reload mode. Both flags stay set until a clearing write arrives.

Some behaviour needs a known history and is shown only by the bench scenarios. This covers the exact machine-cycle rate, the synchronizer latency of count and trigger edges, and the fact that rising edges are ignored. It also covers the reload value after overflow and after a trigger, the toggle timing, and the PWM level at and around the compare value. The bench compares these against its behavioural model on each clock.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
   localparam logic [ADDR_W-1:0] A_COUNT   = 3'd1;
   localparam logic [ADDR_W-1:0] A_RELOAD  = 3'd2;
   localparam logic [ADDR_W-1:0] A_COMPARE = 3'd3;
   localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd4;

   typedef enum logic [1:0] {
      OUT_OFF    = 2'd0,
      OUT_TOGGLE = 2'd1,
      OUT_PWM    = 2'd2,
      OUT_RSVD   = 2'd3
   } out_mode_e;

   // packed MSB first: out_mode = bits 4:3, cap_mode = bit 2, ext_src = bit 1, run = bit 0
   typedef struct packed {
      out_mode_e out_mode;
      logic      cap_mode;
      logic      ext_src;
      logic      run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ctmr_tick_gen.sv
module ctmr_tick_gen #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("ctmr_tick_gen: DIV must be at least 1");
      end

      if (DIV <= 1) begin : g_every
         logic unused_w;
         assign unused_w = clk ^ rst_n;
         assign tick_o   = 1'b1;
      end else begin : g_div
         localparam int              DW   = $clog2(DIV);
         localparam logic [DW-1:0]   LAST = DW'(DIV - 1);
         logic [DW-1:0] div_q;

         assign tick_o = (div_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      div_q <= '0;
            else if (tick_o) div_q <= '0;
            else             div_q <= div_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/ctmr_edge_sampler.sv
module ctmr_edge_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic sample_i,
   output logic fall_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ctmr_edge_sampler: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   // machine-cycle sample of the synchronized level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_q <= 1'b0;
      else if (sample_i) prev_q <= sync_q[STAGES-1];
   end

   assign fall_o = sample_i & prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cnt_fall_i,
   input  logic             trg_fall_i,
   input  logic             run_i,
   input  logic             ext_src_i,
   input  logic             cap_mode_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             clr_ovf_i,
   input  logic             clr_trg_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] capture_o,
   output logic             ovf_flag_o,
   output logic             trg_flag_o,
   output logic             ovf_evt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] count_q, count_d;
   logic [CNT_W-1:0] cap_q;
   logic [CNT_W-1:0] wrap_val;
   logic             ovf_q, trg_q;
   logic             count_evt, trg_evt, ovf_evt;

   assign count_evt = run_i & tick_i & (ext_src_i ? cnt_fall_i : 1'b1);
   assign trg_evt   = run_i & trg_fall_i;
   assign ovf_evt   = count_evt & (count_q == CNT_MAX);
   assign wrap_val  = cap_mode_i ? '0 : reload_i;

   // priority: software write, then trigger reload, then increment
   always_comb begin
      count_d = count_q;
      if (cnt_wr_i)                    count_d = wr_data_i;
      else if (!cap_mode_i && trg_evt) count_d = reload_i;
      else if (count_evt)              count_d = ovf_evt ? wrap_val : count_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cap_q <= '0;
      else if (cap_mode_i && trg_evt)  cap_q <= count_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         trg_q <= 1'b0;
      end else begin
         if (ovf_evt)        ovf_q <= 1'b1;
         else if (clr_ovf_i) ovf_q <= 1'b0;
         if (trg_evt)        trg_q <= 1'b1;
         else if (clr_trg_i) trg_q <= 1'b0;
      end
   end

   assign count_o    = count_q;
   assign capture_o  = cap_q;
   assign ovf_flag_o = ovf_q;
   assign trg_flag_o = trg_q;
   assign ovf_evt_o  = ovf_evt;

endmodule

// File: rtl/ctmr_out_stage.sv
module ctmr_out_stage
   import ctmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit PWM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  out_mode_e        out_mode_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] compare_i,
   input  logic             ovf_evt_i,
   output logic             out_o
);

   logic tog_q;
   logic pwm_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     tog_q <= 1'b0;
      else if (ovf_evt_i && out_mode_i == OUT_TOGGLE) tog_q <= ~tog_q;
   end

   generate
      if (PWM_EN) begin : g_pwm
         assign pwm_lvl = (count_i < compare_i);
      end else begin : g_no_pwm
         logic unused_w;
         assign unused_w = ^{count_i, compare_i};
         assign pwm_lvl  = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (out_mode_i)
         OUT_TOGGLE: out_o = tog_q;
         OUT_PWM:    out_o = pwm_lvl;
         default:    out_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
   import ctmr_pkg::*;
#(
   parameter int CNT_W         = 16,
   parameter int CLKS_PER_TICK = 2,
   parameter int SYNC_STAGES   = 2,
   parameter bit PWM_EN        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic              cnt_pin_i,
   input  logic              trg_pin_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  capture_o,
   output logic              ovf_flag_o,
   output logic              trg_flag_o,
   output logic              out_pin_o
);

   localparam int NUM_PINS = 2;
   localparam int PIN_CNT  = 0;
   localparam int PIN_TRG  = 1;

   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("cap_reload_timer: CNT_W must be at least 8");
      end
      if (CLKS_PER_TICK < 1) begin : g_bad_tick
         $error("cap_reload_timer: CLKS_PER_TICK must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cap_reload_timer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // register file
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] compare_q;

   logic cnt_wr_w, clr_ovf_w, clr_trg_w;
   logic run_w, cap_w;

   assign cnt_wr_w  = wr_en_i && (wr_addr_i == A_COUNT);
   assign clr_ovf_w = wr_en_i && (wr_addr_i == A_FLAGS) && !wr_data_i[0];
   assign clr_trg_w = wr_en_i && (wr_addr_i == A_FLAGS) && !wr_data_i[1];
   assign run_w     = ctrl_q.run;
   assign cap_w     = ctrl_q.cap_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         reload_q  <= '0;
         compare_q <= '0;
      end else if (wr_en_i) begin
         case (wr_addr_i)
            A_CTRL:    ctrl_q    <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
            A_RELOAD:  reload_q  <= wr_data_i;
            A_COMPARE: compare_q <= wr_data_i;
            default:   ;
         endcase
      end
   end

   // machine-cycle tick
   logic tick_w;

   ctmr_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick_w)
   );

   // edge samplers for count and trigger pins
   logic [NUM_PINS-1:0] pins_w;
   logic [NUM_PINS-1:0] fall_w;

   assign pins_w[PIN_CNT] = cnt_pin_i;
   assign pins_w[PIN_TRG] = trg_pin_i;

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         ctmr_edge_sampler #(.STAGES(SYNC_STAGES)) u_samp (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pins_w[p]),
            .sample_i (tick_w),
            .fall_o   (fall_w[p])
         );
      end
   endgenerate

   logic ovf_evt_w;

   ctmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_w),
      .cnt_fall_i (fall_w[PIN_CNT]),
      .trg_fall_i (fall_w[PIN_TRG]),
      .run_i      (ctrl_q.run),
      .ext_src_i  (ctrl_q.ext_src),
      .cap_mode_i (ctrl_q.cap_mode),
      .reload_i   (reload_q),
      .cnt_wr_i   (cnt_wr_w),
      .wr_data_i  (wr_data_i),
      .clr_ovf_i  (clr_ovf_w),
      .clr_trg_i  (clr_trg_w),
      .count_o    (count_o),
      .capture_o  (capture_o),
      .ovf_flag_o (ovf_flag_o),
      .trg_flag_o (trg_flag_o),
      .ovf_evt_o  (ovf_evt_w)
   );

   ctmr_out_stage #(.CNT_W(CNT_W), .PWM_EN(PWM_EN)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .out_mode_i (ctrl_q.out_mode),
      .count_i    (count_o),
      .compare_i  (compare_q),
      .ovf_evt_i  (ovf_evt_w),
      .out_o      (out_pin_o)
   );

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_wr,
   input logic             clr_ovf,
   input logic             clr_trg,
   input logic             run,
   input logic             cap_mode,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] capture,
   input logic             ovf_flag,
   input logic             trg_flag
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && !run) |=> $stable(count)); // R10

   AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_mode |=> $stable(capture)); // R6

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && cap_mode && count != CNT_MAX)
      |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R2

   AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && cap_mode && count == CNT_MAX)
      |=> (count == CNT_MAX || (count == '0 && ovf_flag))); // R6

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_ovf) |=> ovf_flag); // R7

   AST_TRG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (trg_flag && !clr_trg) |=> trg_flag); // R7

endmodule

bind cap_reload_timer ctmr_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_wr   (cnt_wr_w),
   .clr_ovf  (clr_ovf_w),
   .clr_trg  (clr_trg_w),
   .run      (run_w),
   .cap_mode (cap_w),
   .count    (count_o),
   .capture  (capture_o),
   .ovf_flag (ovf_flag_o),
   .trg_flag (trg_flag_o)
);

// File: tb/cap_reload_timer_tb_top.sv
module cap_reload_timer_tb_top;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic          cnt_pin = 1'b0;
   logic          trg_pin = 1'b0;
   logic [W-1:0]  count, capture;
   logic          ovf_flag, trg_flag, out_pin;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   string cur_tag = "R1";
   bit cmp_on = 1'b0;

   always #10 clk = ~clk;

   cap_reload_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .cnt_pin_i(cnt_pin), .trg_pin_i(trg_pin),
      .count_o(count), .capture_o(capture), .ovf_flag_o(ovf_flag),
      .trg_flag_o(trg_flag), .out_pin_o(out_pin)
   );

   // behavioural reference model
   logic [W-1:0] m_cnt, m_cap, m_rel, m_cmp;
   logic [4:0]   m_ctrl;
   logic         m_ovf, m_trg, m_tog;
   logic         qc0, qc1, qt0, qt1, m_prevc, m_prevt;
   int           m_n;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = '0; m_cap = '0; m_rel = '0; m_cmp = '0; m_ctrl = '0;
         m_ovf = 0; m_trg = 0; m_tog = 0;
         qc0 = 0; qc1 = 0; qt0 = 0; qt1 = 0; m_prevc = 0; m_prevt = 0; m_n = 0;
      end else begin
         logic tick, cfall, tfall, evt, trg, ovf, run, ext, capm;
         logic [W-1:0] nc;
         m_n++;
         tick  = (m_n % 2 == 0);
         cfall = tick && m_prevc && !qc0;
         tfall = tick && m_prevt && !qt0;
         if (tick) begin m_prevc = qc0; m_prevt = qt0; end
         qc0 = qc1; qc1 = cnt_pin; qt0 = qt1; qt1 = trg_pin;
         run = m_ctrl[0]; ext = m_ctrl[1]; capm = m_ctrl[2];
         evt = run && tick && (ext ? cfall : 1'b1);
         trg = run && tfall;
         ovf = evt && (m_cnt == 16'hFFFF);
         nc = m_cnt;
         if (wr_en && wr_addr == 3'd1)  nc = wr_data;
         else if (!capm && trg)         nc = m_rel;
         else if (evt)                  nc = ovf ? (capm ? 16'h0 : m_rel) : m_cnt + 16'd1;
         if (capm && trg) m_cap = m_cnt;
         if (ovf) m_ovf = 1;
         else if (wr_en && wr_addr == 3'd4 && !wr_data[0]) m_ovf = 0;
         if (trg) m_trg = 1;
         else if (wr_en && wr_addr == 3'd4 && !wr_data[1]) m_trg = 0;
         if (ovf && m_ctrl[4:3] == 2'd1) m_tog = !m_tog;
         if (wr_en && wr_addr == 3'd0) m_ctrl = wr_data[4:0];
         if (wr_en && wr_addr == 3'd2) m_rel  = wr_data;
         if (wr_en && wr_addr == 3'd3) m_cmp  = wr_data;
         m_cnt = nc;
      end
   end

   function automatic logic m_out();
      case (m_ctrl[4:3])
         2'd1:    return m_tog;
         2'd2:    return m_cnt < m_cmp;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk(count == m_cnt,       cur_tag, "model count",   count,    m_cnt);
         chk(capture == m_cap,     cur_tag, "model capture", capture,  m_cap);
         chk(ovf_flag == m_ovf,    cur_tag, "model ovf",     ovf_flag, m_ovf);
         chk(trg_flag == m_trg,    cur_tag, "model trg",     trg_flag, m_trg);
         chk(out_pin == m_out(),   cur_tag, "model out",     out_pin,  m_out());
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      logic [W-1:0] c0, k0;
      int toggles;
      logic last;

      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      // R1 reset state
      chk(count == 0,    "R1", "count",   count, 0);
      chk(capture == 0,  "R1", "capture", capture, 0);
      chk(ovf_flag == 0, "R1", "ovf",     ovf_flag, 0);
      chk(trg_flag == 0, "R1", "trg",     trg_flag, 0);
      chk(out_pin == 0,  "R1", "out",     out_pin, 0);

      // R2 machine-cycle rate
      cur_tag = "R2";
      wr(3'd0, 16'h0001);
      c0 = count;
      wait_n(40);
      chk(count == c0 + 16'd20, "R2", "count after 40 clocks", count, c0 + 16'd20);

      // R11 software count load
      cur_tag = "R11";
      wr(3'd1, 16'hFFF0);
      chk(count == 16'hFFF0, "R11", "count load", count, 16'hFFF0);

      // R4 overflow reload
      cur_tag = "R4";
      wr(3'd2, 16'h1234);
      wr(3'd1, 16'hFFFE);
      wait_n(6);
      chk(ovf_flag == 1, "R4", "ovf set", ovf_flag, 1);
      chk(count >= 16'h1234 && count <= 16'h1236, "R4", "reload after wrap", count, 16'h1234);

      // R7 clear overflow with bit0=0
      cur_tag = "R7";
      wr(3'd4, 16'h0002);
      chk(ovf_flag == 0, "R7", "ovf cleared", ovf_flag, 0);

      // R5 trigger reload
      cur_tag = "R5";
      trg_pin = 1'b1;
      wait_n(6);
      trg_pin = 1'b0;
      wait_n(8);
      chk(trg_flag == 1, "R5", "trg flag", trg_flag, 1);
      chk(count >= 16'h1234 && count <= 16'h1238, "R5", "count near reload", count, 16'h1234);

      // R7 writing ones keeps, zero clears
      cur_tag = "R7";
      wr(3'd4, 16'h0003);
      chk(trg_flag == 1, "R7", "trg kept by write of 1", trg_flag, 1);
      wr(3'd4, 16'h0001);
      chk(trg_flag == 0, "R7", "trg cleared", trg_flag, 0);

      // R3 external count edges
      cur_tag = "R3";
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'h0003);
      wr(3'd1, 16'h0000);
      cnt_pin = 1'b1;
      wait_n(10);
      chk(count == 0, "R3", "rising edge ignored", count, 0);
      for (int p = 0; p < 5; p++) begin
         cnt_pin = 1'b0; wait_n(6);
         cnt_pin = 1'b1; wait_n(6);
      end
      chk(count == 5, "R3", "five falling edges", count, 5);
      cnt_pin = 1'b0;
      wait_n(6);

      // R6 capture mode
      cur_tag = "R6";
      wr(3'd0, 16'h0005);
      wr(3'd1, 16'd100);
      trg_pin = 1'b1;
      wait_n(6);
      c0 = count;
      trg_pin = 1'b0;
      wait_n(8);
      chk(capture >= c0 && capture <= c0 + 16'd5, "R6", "captured count", capture, c0);
      chk(trg_flag == 1, "R6", "trg flag", trg_flag, 1);
      chk(count > capture, "R6", "count continues", count, capture);
      wr(3'd4, 16'h0000);
      wr(3'd1, 16'hFFFE);
      wait_n(6);
      chk(count <= 16'd2, "R6", "wrap to zero", count, 1);
      chk(ovf_flag == 1, "R6", "ovf on wrap", ovf_flag, 1);

      // R8 toggle output
      cur_tag = "R8";
      wr(3'd4, 16'h0000);
      wr(3'd2, 16'hFFF0);
      wr(3'd0, 16'h0009);
      wr(3'd1, 16'hFFF0);
      chk(out_pin == 0, "R8", "out before overflow", out_pin, 0);
      wait_n(40);
      chk(out_pin == 1, "R8", "out after one overflow", out_pin, 1);
      toggles = 0; last = out_pin;
      for (int i = 0; i < 128; i++) begin
         @(negedge clk);
         if (out_pin != last) toggles++;
         last = out_pin;
      end
      chk(toggles == 4, "R8", "toggles in 128 clocks", toggles, 4);

      // R9 PWM level
      cur_tag = "R9";
      wr(3'd0, 16'h0010);
      wr(3'd3, 16'hFFF8);
      wr(3'd1, 16'hFFF2);
      chk(out_pin == 1, "R9", "below compare", out_pin, 1);
      wr(3'd1, 16'hFFF8);
      chk(out_pin == 0, "R9", "equal compare", out_pin, 0);
      wr(3'd1, 16'hFFFA);
      chk(out_pin == 0, "R9", "above compare", out_pin, 0);
      wr(3'd0, 16'h0011);
      wait_n(100);
      wr(3'd0, 16'h0018);
      chk(out_pin == 0, "R9", "reserved mode low", out_pin, 0);

      // R10 stopped counter ignores trigger
      cur_tag = "R10";
      wr(3'd4, 16'h0000);
      wr(3'd0, 16'h0004);
      k0 = count; c0 = capture;
      trg_pin = 1'b1; wait_n(6);
      trg_pin = 1'b0; wait_n(8);
      chk(count == k0,   "R10", "count held", count, k0);
      chk(capture == c0, "R10", "capture held", capture, c0);
      chk(trg_flag == 0, "R10", "trg flag untouched", trg_flag, 0);

      cmp_on = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule